// File: doc/BRIEF.md
# Infrared Manchester Frame Transmitter

This block turns a key press into one fourteen-cell remote-control frame. An active-low request strobe loads a 4-bit key code. The frame starts once the strobe is released. Each cell is Manchester coded and built from two half-bits. A half-bit is either active, holding a burst of carrier pulses, or silent. The frame carries two start cells, an even-parity cell, a five-bit group address fixed by a parameter (zero by default) and a six-bit data field. The data field holds the key code in its low four bits and zero in its top two.

Two outputs carry the frame. The infrared output drives an emitter stage with the modulated carrier. The envelope output is an inverted, carrier-free copy of the half-bit pattern, meant for probing. After each frame a quiet holdoff runs before a new request is accepted. A busy flag covers the span from the key latch to the end of that holdoff. All timing is counted in clock cycles. With a 4 MHz clock the defaults give the following:

- a carrier period of 108 cycles;
- a half-bit of 3556 cycles;
- a holdoff of 262144 cycles, which is 65.536 ms.

Top module: `irf_tx`

## Requirements
- R1: A frame has 14 cells, sent first to last as: start, start, parity, group bits 4 down to 0, then data bits 5 down to 0. The data field is {2'b00, key_code}, and the group field is the parameter GROUP.
- R2: A cell of value 1 is sent as an active half then a silent half. A cell of value 0 is sent as a silent half then an active half. Both start cells are sent as silent then active.
- R3: Each half lasts HALF_BIT cycles. An active half begins with PULSES carrier pulses, each CARRIER_HALF cycles high then CARRIER_HALF cycles low. The infrared output stays low for the rest of that half. It stays low for the whole of a silent half.
- R4: The parity cell equals the XOR of the five group bits and the six data bits, so the eleven bits plus the parity bit hold an even number of ones.
- R5: The envelope output is low exactly during active halves and high at every other time. The infrared output is never high while the envelope is high.
- R6: The key code is latched on the clock edge that first samples the request low after it was high. Later changes to key_code do not alter the frame.
- R7: The first half of the frame begins in the first cycle after the request is sampled high again. While the request stays low, nothing is sent.
- R8: After the last half, the infrared output stays low and busy stays high for HOLDOFF cycles. The block then returns to idle.
- R9: busy is high from the latch cycle to the end of the holdoff. A request falling edge that arrives while busy is high is ignored.
- R10: A synchronous active-low reset forces the infrared output low, the envelope high and busy low, including in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 1 | Data-available strobe, active low |
| key_code | input | 4 | Key code sampled on the request falling edge |
| ir_tx | output | 1 | Modulated infrared emitter drive |
| env_n | output | 1 | Inverted carrier-free half-bit envelope |
| busy | output | 1 | High from key latch until the end of the holdoff |

## Verification
The bench compares every cycle of each frame against a model built from the cell rules. A wrong cell order, a swapped Manchester polarity on data or start cells, or a pulse or half-bit count that is off by one shows up as a mismatch at a specific cycle. Key codes are chosen to give both parity values, and the group parameter is set to a value other than zero. Swapping the data bytes or the parity sense therefore changes the waveform.

Some tests change the key code after the latch, or hold the request low for several cycles. Others pulse the request during a frame and during the holdoff. A design that sampled the key late, started on the falling edge, or restarted on a busy-time strobe would send the wrong frame or hold busy for the wrong span. The holdoff is measured exactly. One test applies reset in the middle of a frame, which catches a design whose outputs keep toggling.

// File: rtl/irf_pkg.sv
// Package irf_pkg
// Shared state encoding and frame geometry for the infrared frame
// transmitter. Assumes the fourteen-cell, two-halves-per-cell format.
package irf_pkg;
    localparam int CELLS   = 14;
    localparam int HALVES  = 2 * CELLS;
    localparam int GROUP_W = 5;
    localparam int DATA_W  = 6;
    localparam int KEY_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2,
        ST_HOLD  = 2'd3
    } tx_state_t;
endpackage

// File: rtl/irf_frame_fmt.sv
// Module irf_frame_fmt
// Builds the 14-bit cell word from the latched key and the fixed group.
// The cell word is sent MSB first. The two start cells are stored as 0,
// so one Manchester rule covers every cell. Purely combinational.
module irf_frame_fmt
    import irf_pkg::*;
#(
    parameter logic [GROUP_W-1:0] GROUP = '0
) (
    input  logic [KEY_W-1:0] key_q,
    output logic [CELLS-1:0] cells
);
    localparam int PAD_W = DATA_W - KEY_W;

    logic [DATA_W-1:0] data_field;
    logic              parity;

    // Compose data field, even parity and full cell word
    always_comb begin
        data_field = {{PAD_W{1'b0}}, key_q};
        parity     = ^{GROUP, data_field};
        cells      = {2'b00, parity, GROUP, data_field};
    end
endmodule

// File: rtl/irf_cell_timer.sv
// Module irf_cell_timer
// Counts cycles within each half-bit, carrier phase and pulse number,
// and the half-bit index across the frame. Holds all counters at zero
// while run is low. Assumes HALF_BIT >= 2*CARRIER_HALF*PULSES.
module irf_cell_timer
    import irf_pkg::*;
#(
    parameter int CARRIER_HALF = 54,
    parameter int PULSES       = 32,
    parameter int HALF_BIT     = 3556
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    output logic [$clog2(HALVES)-1:0] half_idx,
    output logic                      carrier_on,
    output logic                      frame_done
);
    localparam int PERIOD = 2 * CARRIER_HALF;
    localparam int HC_W   = $clog2(HALF_BIT);
    localparam int CC_W   = $clog2(PERIOD);
    localparam int PC_W   = $clog2(PULSES + 1);
    localparam int HI_W   = $clog2(HALVES);

    logic [HC_W-1:0] half_cnt;
    logic [CC_W-1:0] phase_cnt;
    logic [PC_W-1:0] pulse_cnt;
    logic            half_end;
    logic            last_half;

    // Decode half-bit end, frame end and carrier level
    always_comb begin
        half_end   = (half_cnt == HC_W'(HALF_BIT - 1));
        last_half  = (half_idx == HI_W'(HALVES - 1));
        frame_done = run && half_end && last_half;
        carrier_on = (pulse_cnt < PC_W'(PULSES)) && (phase_cnt < CC_W'(CARRIER_HALF));
    end

    // Advance half-bit, carrier phase and pulse counters
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            half_cnt  <= '0;
            phase_cnt <= '0;
            pulse_cnt <= '0;
            half_idx  <= '0;
        end else if (half_end) begin
            half_cnt  <= '0;
            phase_cnt <= '0;
            pulse_cnt <= '0;
            half_idx  <= last_half ? '0 : half_idx + 1'b1;
        end else begin
            half_cnt <= half_cnt + 1'b1;
            if (phase_cnt == CC_W'(PERIOD - 1)) begin
                phase_cnt <= '0;
                if (pulse_cnt != PC_W'(PULSES))
                    pulse_cnt <= pulse_cnt + 1'b1;
            end else begin
                phase_cnt <= phase_cnt + 1'b1;
            end
        end
    end

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pulse_cnt <= PC_W'(PULSES)))                          // R3
        else $error("pulse count beyond limit");
    AST_HALF_START_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        (run && half_end && !last_half) |=> (carrier_on == (PULSES > 0)))  // R3
        else $error("half-bit did not start on a carrier pulse");
endmodule

// File: rtl/irf_tx.sv
// Module irf_tx
// Top of the infrared frame transmitter. It detects the request falling
// edge, latches the key, waits for release, sequences the frame through
// the cell timer and runs the holdoff. Assumes req_n is already
// synchronous to clk.
module irf_tx
    import irf_pkg::*;
#(
    parameter int                 CARRIER_HALF = 54,
    parameter int                 PULSES       = 32,
    parameter int                 HALF_BIT     = 3556,
    parameter int                 HOLDOFF      = 262144,
    parameter logic [GROUP_W-1:0] GROUP        = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_n,
    input  logic [KEY_W-1:0] key_code,
    output logic             ir_tx,
    output logic             env_n,
    output logic             busy
);
    localparam int HO_W = $clog2(HOLDOFF + 1);
    localparam int HI_W = $clog2(HALVES);

    tx_state_t        state;
    logic             req_q;
    logic             req_fall;
    logic [KEY_W-1:0] key_q;
    logic [HO_W-1:0]  hold_cnt;
    logic [CELLS-1:0] cells;
    logic [HI_W-1:0]  half_idx;
    logic             carrier_on;
    logic             frame_done;
    logic             cur_bit;
    logic             active;

    irf_frame_fmt #(.GROUP(GROUP)) u_fmt (
        .key_q (key_q),
        .cells (cells)
    );

    irf_cell_timer #(
        .CARRIER_HALF(CARRIER_HALF),
        .PULSES      (PULSES),
        .HALF_BIT    (HALF_BIT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (state == ST_SEND),
        .half_idx   (half_idx),
        .carrier_on (carrier_on),
        .frame_done (frame_done)
    );

    // Remember the previous request level for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b1;
        else        req_q <= req_n;
    end

    // Select the current cell and decide whether this half is active
    always_comb begin
        req_fall = req_q && !req_n;
        cur_bit  = cells[CELLS - 1 - int'(half_idx >> 1)];
        active   = (state == ST_SEND) && (cur_bit ^ half_idx[0]);
        ir_tx    = active && carrier_on;
        env_n    = !active;
        busy     = (state != ST_IDLE);
    end

    // Request, send and holdoff sequencing with key latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            key_q    <= '0;
            hold_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_fall) begin
                    key_q <= key_code;
                    state <= ST_ARMED;
                end
                ST_ARMED: if (req_n) state <= ST_SEND;
                ST_SEND: if (frame_done) begin
                    hold_cnt <= '0;
                    state    <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (hold_cnt == HO_W'(HOLDOFF - 1)) state <= ST_IDLE;
                    hold_cnt <= hold_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ir_tx && env_n))                                    // R5
        else $error("output active while idle");
    AST_CARRIER_IN_ENVELOPE: assert property (@(posedge clk) disable iff (!rst_n)
        ir_tx |-> !env_n)                                               // R5
        else $error("carrier outside envelope");
    AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !req_n) |=> (state == ST_ARMED && !ir_tx))  // R7
        else $error("frame began before request release");
    AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(key_q))                       // R6
        else $error("latched key changed while busy");
    AST_FRAME_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (state == ST_HOLD && !ir_tx && busy))            // R8
        else $error("frame end did not enter holdoff");
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_fall && state != ST_HOLD) |=> busy)                // R9
        else $error("busy dropped on a request edge");
endmodule

// File: tb/tb_irf_tx.sv
// Directed bench for irf_tx using short timing parameters.
module tb_irf_tx;
    localparam int CH  = 2;
    localparam int NP  = 3;
    localparam int HB  = 16;
    localparam int HO  = 40;
    localparam logic [4:0] GRP = 5'b10110;
    localparam int NHALF = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n = 1'b1;
    logic [3:0] key_code = 4'h0;
    logic       ir_tx, env_n, busy;
    int         n_run = 0;
    int         n_fail = 0;

    irf_tx #(.CARRIER_HALF(CH), .PULSES(NP), .HALF_BIT(HB), .HOLDOFF(HO), .GROUP(GRP)) dut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .key_code(key_code),
        .ir_tx(ir_tx), .env_n(env_n), .busy(busy));

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cell word: start 0, start 0, parity, group, {00,key} (R1, R2, R4)
    function automatic logic [13:0] model_cells(input logic [3:0] k);
        logic [5:0] d = {2'b00, k};
        logic p = 1'b0;
        for (int i = 0; i < 5; i++) p = p ^ GRP[i];
        for (int i = 0; i < 6; i++) p = p ^ d[i];
        return {2'b00, p, GRP, d};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; req_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R10: idle levels after reset
    task automatic t_reset_state();
        do_reset();
        check("R10 ir_tx after reset", ir_tx, 0);
        check("R10 env_n after reset", env_n, 1);
        check("R10 busy after reset", busy, 0);
    endtask

    // Full frame with the key changed after the latch and optional busy-time strobes
    task automatic t_frame(input logic [3:0] k, input bit poke_send, input bit poke_hold);
        logic [13:0] c = model_cells(k);
        int bad = 0, first_j = -1, bad_act = 0, bad_exp = 0, low_ir = 0, hold = 0;
        @(negedge clk); req_n = 1'b0; key_code = k;
        @(negedge clk); key_code = ~k;
        check("R9 busy after latch", busy, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (ir_tx || !env_n) low_ir++;
        end
        check("R7 quiet while request low", low_ir, 0);
        req_n = 1'b1;
        for (int j = 0; j < NHALF * HB; j++) begin
            int hi = j / HB, hc = j % HB;
            logic b = c[13 - hi / 2];
            logic act = (hi % 2 == 0) ? b : ~b;
            logic e_ir = act && (hc < 2 * CH * NP) && ((hc % (2 * CH)) < CH);
            @(negedge clk);
            if (ir_tx != e_ir || env_n != !act) begin
                if (first_j < 0) begin first_j = j; bad_act = {ir_tx, env_n}; bad_exp = {e_ir, !act}; end
                bad++;
            end
            if (poke_send && j == 100) req_n = 1'b0;
            if (poke_send && j == 101) req_n = 1'b1;
        end
        check($sformatf("R1 R2 R3 R4 R5 R6 frame key %0h {ir,env} at cycle %0d", k, first_j),
              bad_act, bad_exp);
        while (busy && hold < 4 * HO) begin
            @(negedge clk);
            if (busy) hold++;
            if (ir_tx) low_ir++;
            if (poke_hold && hold == 5) req_n = 1'b0;
            if (poke_hold && hold == 6) req_n = 1'b1;
        end
        check("R8 holdoff length", hold, HO);
        check("R8 ir low during holdoff", low_ir, 0);
        repeat (4) @(negedge clk);
        check("R9 no frame from busy-time strobe", busy, 0);
    endtask

    // R10: reset in the middle of a frame
    task automatic t_mid_reset();
        @(negedge clk); req_n = 1'b0; key_code = 4'hF;
        @(negedge clk); req_n = 1'b1;
        repeat (HB + 1) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 ir_tx mid-frame reset", ir_tx, 0);
        check("R10 env_n mid-frame reset", env_n, 1);
        check("R10 busy mid-frame reset", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_frame(4'hA, 1'b0, 1'b0);
        t_frame(4'h5, 1'b1, 1'b0);
        t_frame(4'h7, 1'b0, 1'b1);
        t_frame(4'h0, 1'b1, 1'b1);
        t_mid_reset();
        t_frame(4'hC, 1'b0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule